// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block handles RTS/CTS handshaking for a single UART channel. It sits between the receive FIFO, the transmit serializer and the two modem-control pins. On the receive side it compares the live RX FIFO fill level with a programmable threshold and drives the active-low RTS pin. RTS is pulled back (driven high) once the FIFO is filled to the threshold. On the transmit side it watches the active-low CTS pin through a synchronizer. It withholds permission for new start bits while the peer is not ready. A character the serializer has already started is not affected, because only the start permit is gated.

Software programs one control word. The word holds the threshold, separate receive and transmit automation enables, and an interrupt enable. Reading the word back also shows the synchronized CTS level and the present RTS pin level. Any edge on the synchronized CTS sets a sticky status flag. The flag raises the interrupt when enabled and stays set until software clears it.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset, RTS is asserted (rts_no = 0), transmission is not gated, the status flag and interrupt are 0, and the control word reads 0x1000 while CTS is held high.
- R2: With the receive enable (bit 8) set, rts_no is 1 when rx_level_i is at or above the threshold in bits [7:0], and 0 when it is below. The pin follows the level one clock after it changes.
- R3: With the receive enable set, a threshold of 0 keeps RTS deasserted at any level. A threshold of 0x70 holds RTS asserted at level 0x6F and deasserts it at 0x70.
- R4: With the receive enable clear, rts_no stays 0 at every FIFO level.
- R5: With the transmit gate (bit 9) set, tx_go_o equals tx_req_i while the synchronized CTS is low, and is 0 while it is high. A CTS change reaches tx_go_o after two clock edges.
- R6: With the transmit gate clear, tx_go_o equals tx_req_i whatever the CTS level.
- R7: The control word reads back bits [7:0], 8, 9 and 14 as written. Bit 12 shows the synchronized CTS level (1 = peer not ready) and bit 13 shows the rts_no level. Writes to bits 12 and 13 have no effect, and all other bits read 0.
- R8: Either edge of the synchronized CTS sets irq_stat_o on the third clock edge after the pin changes. The flag holds until irq_clr_i is pulsed. irq_o is irq_stat_o masked by bit 14.
- R9: A CTS change that sets the flag in the same cycle as an irq_clr_i pulse wins, and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word write data |
| ctl_rdata_o | output | 16 | Control word read data with pin status |
| irq_clr_i | input | 1 | Clears the CTS-change flag |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| cts_ni | input | 1 | Raw CTS pin, active low |
| tx_req_i | input | 1 | Serializer ready to begin a character |
| rts_no | output | 1 | RTS pin, active low |
| tx_go_o | output | 1 | Permit for the serializer to send a start bit |
| irq_stat_o | output | 1 | Sticky CTS-change flag |
| irq_o | output | 1 | Masked CTS-change interrupt |

## Verification
Two events can land in the same clock edge: a synchronized CTS edge setting the change flag, and a software clear of that flag. The bench first clears the flag. It then drops the CTS pin and pulses irq_clr_i exactly in the cycle where the edge detector fires. A clear that took priority would leave the flag at 0, so the bench expects the flag to read 1 afterwards. The expected values of all checks are queued by the stimulus tasks and compared by a separate monitor.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int unsigned CTL_W       = 16;
  localparam int unsigned THR_W       = 8;
  localparam int unsigned RX_AUTO_BIT = 8;
  localparam int unsigned TX_GATE_BIT = 9;
  localparam int unsigned CTS_ST_BIT  = 12;
  localparam int unsigned RTS_ST_BIT  = 13;
  localparam int unsigned IRQ_EN_BIT  = 14;

  typedef struct packed {
    logic             irq_en;
    logic             tx_gate;
    logic             rx_auto;
    logic [THR_W-1:0] thr;
  } fc_cfg_t;
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_ni,
  output logic cts_n_sync_o,
  output logic chg_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[0] <= 1'b1;
          else         sr_q[0] <= cts_ni;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[i] <= 1'b1;
          else         sr_q[i] <= sr_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sr_q[STAGES-1];

  assign cts_n_sync_o = sr_q[STAGES-1];
  assign chg_o        = sr_q[STAGES-1] ^ prev_q;

  assert_chg_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/fc_rts_gen.sv
module fc_rts_gen #(
  parameter int unsigned LVL_W = 8,
  parameter int unsigned THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_auto_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             rts_no
);
  localparam int unsigned CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CMP_W-1:0] lvl_ext, thr_ext;
  logic             rts_n_q;

  always_comb begin
    lvl_ext = '0;
    thr_ext = '0;
    lvl_ext[LVL_W-1:0] = level_i;
    thr_ext[THR_W-1:0] = thr_i;
  end

  // high = peer must pause
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rts_n_q <= 1'b0;
    else         rts_n_q <= rx_auto_i && (lvl_ext >= thr_ext);

  assign rts_no = rts_n_q;

  assert_rts_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_auto_i && (lvl_ext >= thr_ext)) |=> rts_no);
  assert_rts_room_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_auto_i && (lvl_ext < thr_ext)) |=> !rts_no);
  assert_rts_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_auto_i |=> !rts_no);
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic gate_en_i,
  input  logic cts_n_i,
  input  logic tx_req_i,
  output logic tx_go_o
);
  // only the start of a character is withheld
  assign tx_go_o = tx_req_i && !(gate_en_i && cts_n_i);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import uart_fc_pkg::*;
#(
  parameter int unsigned LVL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  input  logic             irq_clr_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             cts_ni,
  input  logic             tx_req_i,
  output logic             rts_no,
  output logic             tx_go_o,
  output logic             irq_stat_o,
  output logic             irq_o
);
  fc_cfg_t cfg_q;
  logic    cts_n_sync, cts_chg, irq_stat_q;
  logic    unused_wdata;

  assign unused_wdata = ^{ctl_wdata_i[CTL_W-1], ctl_wdata_i[RTS_ST_BIT],
                          ctl_wdata_i[CTS_ST_BIT], ctl_wdata_i[11:10]};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cfg_q <= '0;
    else if (ctl_we_i) begin
      cfg_q.thr     <= ctl_wdata_i[THR_W-1:0];
      cfg_q.rx_auto <= ctl_wdata_i[RX_AUTO_BIT];
      cfg_q.tx_gate <= ctl_wdata_i[TX_GATE_BIT];
      cfg_q.irq_en  <= ctl_wdata_i[IRQ_EN_BIT];
    end

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cts_ni       (cts_ni),
    .cts_n_sync_o (cts_n_sync),
    .chg_o        (cts_chg)
  );

  fc_rts_gen #(.LVL_W(LVL_W), .THR_W(THR_W)) u_rts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_auto_i (cfg_q.rx_auto),
    .thr_i     (cfg_q.thr),
    .level_i   (rx_level_i),
    .rts_no    (rts_no)
  );

  fc_tx_gate u_gate (
    .gate_en_i (cfg_q.tx_gate),
    .cts_n_i   (cts_n_sync),
    .tx_req_i  (tx_req_i),
    .tx_go_o   (tx_go_o)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        irq_stat_q <= 1'b0;
    else if (cts_chg)   irq_stat_q <= 1'b1;
    else if (irq_clr_i) irq_stat_q <= 1'b0;

  assign irq_stat_o = irq_stat_q;
  assign irq_o      = irq_stat_q && cfg_q.irq_en;

  always_comb begin
    ctl_rdata_o              = '0;
    ctl_rdata_o[THR_W-1:0]   = cfg_q.thr;
    ctl_rdata_o[RX_AUTO_BIT] = cfg_q.rx_auto;
    ctl_rdata_o[TX_GATE_BIT] = cfg_q.tx_gate;
    ctl_rdata_o[CTS_ST_BIT]  = cts_n_sync;
    ctl_rdata_o[RTS_ST_BIT]  = rts_no;
    ctl_rdata_o[IRQ_EN_BIT]  = cfg_q.irq_en;
  end

  assert_gate_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[TX_GATE_BIT] && ctl_rdata_o[CTS_ST_BIT]) |-> !tx_go_o);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_q && !irq_clr_i) |=> irq_stat_q);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !cts_chg) |=> !irq_stat_q);
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_chg |=> irq_stat_q);
endmodule

// File: tb/uart_flow_ctl_tb_top.sv
module uart_flow_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        irq_clr = 1'b0;
  logic [7:0]  rx_level = '0;
  logic        cts_n = 1'b1;
  logic        tx_req = 1'b1;
  logic        rts_n, tx_go, irq_stat, irq;

  always #2 clk = ~clk;

  uart_flow_ctl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctl_we_i    (ctl_we),
    .ctl_wdata_i (ctl_wdata),
    .ctl_rdata_o (ctl_rdata),
    .irq_clr_i   (irq_clr),
    .rx_level_i  (rx_level),
    .cts_ni      (cts_n),
    .tx_req_i    (tx_req),
    .rts_no      (rts_n),
    .tx_go_o     (tx_go),
    .irq_stat_o  (irq_stat),
    .irq_o       (irq)
  );

  typedef enum int {K_RTS, K_GO, K_IRQ, K_STAT, K_RD} kind_e;
  typedef struct {
    kind_e       kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic expect_val(kind_e k, logic [15:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
    -> chk_ev;
    #0.1;
  endtask

  // monitor: pops expectations and compares against live outputs
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RTS:   act = {15'd0, rts_n};
        K_GO:    act = {15'd0, tx_go};
        K_IRQ:   act = {15'd0, irq};
        K_STAT:  act = {15'd0, irq_stat};
        default: act = ctl_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=0x%04h expected=0x%04h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(logic [15:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    expect_val(K_RTS, 16'h0, "R1");
    expect_val(K_GO, 16'h1, "R1");
    expect_val(K_IRQ, 16'h0, "R1");
    expect_val(K_STAT, 16'h0, "R1");
    expect_val(K_RD, 16'h1000, "R1");

    // threshold 0x70, receive automation on
    rx_level = 8'h6F;
    wr_ctl(16'h0170); step(1);
    expect_val(K_RTS, 16'h0, "R3");
    rx_level = 8'h70; step(1);
    expect_val(K_RTS, 16'h1, "R3");
    expect_val(K_RD, 16'h3170, "R7");
    rx_level = 8'h71; step(1);
    expect_val(K_RTS, 16'h1, "R2");
    rx_level = 8'h05; step(1);
    expect_val(K_RTS, 16'h0, "R2");

    wr_ctl(16'h0100); step(1);
    expect_val(K_RTS, 16'h1, "R3");
    rx_level = 8'hFF;
    wr_ctl(16'h0000); step(1);
    expect_val(K_RTS, 16'h0, "R4");

    // transmit gating, CTS high = peer not ready; status bits written as 1
    wr_ctl(16'h3200);
    expect_val(K_GO, 16'h0, "R5");
    expect_val(K_RD, 16'h1200, "R7");

    cts_n = 1'b0; step(1);
    expect_val(K_GO, 16'h0, "R5");
    step(1);
    expect_val(K_GO, 16'h1, "R5");
    expect_val(K_STAT, 16'h0, "R8");
    step(1);
    expect_val(K_STAT, 16'h1, "R8");
    expect_val(K_IRQ, 16'h0, "R8");
    wr_ctl(16'h4200);
    expect_val(K_IRQ, 16'h1, "R8");
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    expect_val(K_STAT, 16'h0, "R8");
    expect_val(K_IRQ, 16'h0, "R8");
    tx_req = 1'b0;
    expect_val(K_GO, 16'h0, "R5");

    // gate off: CTS deasserted does not block
    wr_ctl(16'h4000);
    cts_n = 1'b1; step(3);
    tx_req = 1'b1; #0.1;
    expect_val(K_GO, 16'h1, "R6");
    expect_val(K_STAT, 16'h1, "R8");
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    expect_val(K_STAT, 16'h0, "R8");

    // clear colliding with a CTS change: set wins
    cts_n = 1'b0; step(2);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    expect_val(K_STAT, 16'h1, "R9");
    step(1);
    expect_val(K_STAT, 16'h1, "R9");
    expect_val(K_RD, 16'h4000, "R7");

    step(2);
    done = 1'b1;
    finish_run();
  end
endmodule